// File: doc/BRIEF.md
# Dual-Port RAM with Address-Collision Arbitration

This block is a synchronous storage array with two identical ports, A and B. Each port can read or write any word on any clock cycle. When both ports are enabled on the same word, an arbiter decides which port holds the word and raises a BUSY flag toward the other port. A port whose BUSY is high has its write discarded. Its read still goes through.

The arbiter picks the port that reached the shared word first. A port has been there first when it was already enabled on that word in the previous cycle. This covers two cases: the second enable arriving on a matching address, and two enabled ports whose addresses come to match. When both ports arrive in the same cycle, a priority bit breaks the tie. It favours port A after reset and flips at every tie.

A mode input selects the source of BUSY. In master mode the internal arbiter drives BUSY. In slave mode each port takes its BUSY from an external input, which a master elsewhere in the system would drive.

Top module: `dual_port_collision_ram`

## Requirements
- R1: In master mode, in any cycle where both enables are high and the two addresses are equal, exactly one of `a_busy_o` and `b_busy_o` is high in that same cycle. In every other cycle both are low.
- R2: `a_busy_o` and `b_busy_o` are never high together.
- R3: A port counts as holding the word when it was enabled on that same address in the previous cycle. In a new collision, the holding port wins and the other port is flagged. While both ports stay enabled on the same address, the flag stays on the same port.
- R4: When neither port, or both ports without an active collision, was holding the word, the cycle is a tie. The first tie after reset flags port B. Each later tie flags the port that was not flagged at the previous tie.
- R5: A write from a port whose effective BUSY is high leaves memory unchanged. The same write, issued again once BUSY is low, takes effect.
- R6: With `slave_mode`=1, each port's effective BUSY equals its `*_busy_i` input, both `*_busy_o` outputs are low, and the internal arbiter has no effect.
- R7: In slave mode, if both ports write the same address in the same cycle with neither BUSY input high, port A's data is stored.
- R8: A read (enable high, write control low) presents the stored word on `*_rdata` one cycle later. Reads are never blocked by BUSY. A read of a word that the other port writes in the same cycle returns the previous contents.
- R9: `*_rdata` keeps its value in any cycle where that port does not read.
- R10: Reset clears both read-data registers to zero and clears the arbiter state. Memory contents are not reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| slave_mode | input | 1 | 1: BUSY is taken from `*_busy_i`; 0: the internal arbiter drives BUSY |
| a_en | input | 1 | Port A enable |
| a_we | input | 1 | Port A write (1) or read (0) |
| a_addr | input | 12 | Port A word address |
| a_wdata | input | 16 | Port A write data |
| a_busy_i | input | 1 | Port A external BUSY (slave mode) |
| a_busy_o | output | 1 | Port A BUSY from the arbiter (master mode) |
| a_rdata | output | 16 | Port A registered read data |
| b_en | input | 1 | Port B enable |
| b_we | input | 1 | Port B write (1) or read (0) |
| b_addr | input | 12 | Port B word address |
| b_wdata | input | 16 | Port B write data |
| b_busy_i | input | 1 | Port B external BUSY (slave mode) |
| b_busy_o | output | 1 | Port B BUSY from the arbiter (master mode) |
| b_rdata | output | 16 | Port B registered read data |

## Verification
The hardest situations to reach from the ports are an exact same-cycle tie, and a collision that arises because one port moves onto the address where the other port is already parked. Random traffic alone seldom produces either. A vector table therefore sets up each case by hand: a second enable arriving on a held word, a port moving onto a held word, and two ties in a row to show the priority flipping. Constrained random traffic then follows, with addresses drawn from a pool of three words and held for several cycles, so that collisions happen often. A reference memory checks that no flagged write ever lands.

// File: rtl/dpc_pkg.sv
package dpc_pkg;
    localparam int unsigned NUM_PORTS = 2;

    typedef enum logic {
        SIDE_A = 1'b0,
        SIDE_B = 1'b1
    } side_e;

    // arbitration control carried from cycle to cycle
    typedef struct packed {
        logic  lock;    // a flagged collision was active last cycle
        side_e loser;   // port flagged by the last decision
        side_e favour;  // port that wins the next tie
    } arb_ctl_t;
endpackage

// File: rtl/dpc_collision_arbiter.sv
module dpc_collision_arbiter
    import dpc_pkg::*;
#(
    parameter int unsigned AW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          arb_on,
    input  logic          a_en,
    input  logic [AW-1:0] a_addr,
    input  logic          b_en,
    input  logic [AW-1:0] b_addr,
    output logic          flag_a,
    output logic          flag_b
);
    typedef struct packed {
        logic          a_en;
        logic          b_en;
        logic [AW-1:0] a_addr;
        logic [AW-1:0] b_addr;
        arb_ctl_t      ctl;
    } arb_state_t;

    arb_state_t st_d, st_q;
    logic       match, held_a, held_b, tie, hit;
    side_e      loser_now;

    always_comb begin
        st_d      = st_q;
        match     = a_en && b_en && (a_addr == b_addr);
        held_a    = st_q.a_en && (st_q.a_addr == a_addr);
        held_b    = st_q.b_en && (st_q.b_addr == b_addr);
        tie       = 1'b0;
        loser_now = st_q.ctl.loser;
        if (match && !(st_q.ctl.lock && held_a && held_b)) begin
            if (held_a && !held_b) begin
                loser_now = SIDE_B;
            end else if (held_b && !held_a) begin
                loser_now = SIDE_A;
            end else begin
                tie       = 1'b1;
                loser_now = (st_q.ctl.favour == SIDE_A) ? SIDE_B : SIDE_A;
            end
        end
        hit    = match && arb_on;
        flag_a = hit && (loser_now == SIDE_A);
        flag_b = hit && (loser_now == SIDE_B);

        st_d.a_en      = a_en;
        st_d.b_en      = b_en;
        st_d.a_addr    = a_addr;
        st_d.b_addr    = b_addr;
        st_d.ctl.lock  = hit;
        st_d.ctl.loser = loser_now;
        if (tie && arb_on) begin
            st_d.ctl.favour = loser_now;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{a_en: 1'b0, b_en: 1'b0, a_addr: '0, b_addr: '0,
                      ctl: '{lock: 1'b0, loser: SIDE_A, favour: SIDE_A}};
        end else begin
            st_q <= st_d;
        end
    end

    // R1
    collide_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (arb_on && a_en && b_en && (a_addr == b_addr)) |-> (flag_a || flag_b));

    // R2
    single_side_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({flag_a, flag_b}));

    // R3
    loser_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((flag_a || flag_b) && $past(rst_n) && $past(flag_a || flag_b)
         && $stable(a_addr) && $stable(b_addr)) |-> $stable(flag_a));
endmodule

// File: rtl/dpc_store.sv
module dpc_store
    import dpc_pkg::*;
#(
    parameter int unsigned AW = 12,
    parameter int unsigned DW = 16
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_PORTS-1:0]          wr_i,
    input  logic [NUM_PORTS-1:0]          rd_i,
    input  logic [NUM_PORTS-1:0][AW-1:0]  addr_i,
    input  logic [NUM_PORTS-1:0][DW-1:0]  wdata_i,
    output logic [NUM_PORTS-1:0][DW-1:0]  rdata_o
);
    localparam int unsigned DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    // descending order: the lowest port index is written last and wins
    always_ff @(posedge clk) begin
        for (int p = NUM_PORTS - 1; p >= 0; p--) begin
            if (wr_i[p]) begin
                mem[addr_i[p]] <= wdata_i[p];
            end
        end
    end

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_rd
        logic [DW-1:0] rdata_d, rdata_q;

        always_comb begin
            rdata_d = rdata_q;
            if (rd_i[p]) begin
                rdata_d = mem[addr_i[p]];
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                rdata_q <= '0;
            end else begin
                rdata_q <= rdata_d;
            end
        end

        assign rdata_o[p] = rdata_q;

        // R9
        rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !rd_i[p] |=> $stable(rdata_o[p]));
    end
endmodule

// File: rtl/dual_port_collision_ram.sv
module dual_port_collision_ram
    import dpc_pkg::*;
#(
    parameter int unsigned AW = 12,
    parameter int unsigned DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          slave_mode,
    input  logic          a_en,
    input  logic          a_we,
    input  logic [AW-1:0] a_addr,
    input  logic [DW-1:0] a_wdata,
    input  logic          a_busy_i,
    output logic          a_busy_o,
    output logic [DW-1:0] a_rdata,
    input  logic          b_en,
    input  logic          b_we,
    input  logic [AW-1:0] b_addr,
    input  logic [DW-1:0] b_wdata,
    input  logic          b_busy_i,
    output logic          b_busy_o,
    output logic [DW-1:0] b_rdata
);
    logic                         arb_a, arb_b;
    logic                         busy_eff_a, busy_eff_b;
    logic [NUM_PORTS-1:0]         wr_go, rd_go;
    logic [NUM_PORTS-1:0][AW-1:0] addr_v;
    logic [NUM_PORTS-1:0][DW-1:0] wdata_v, rdata_v;

    dpc_collision_arbiter #(.AW(AW)) i_arb (
        .clk    (clk),
        .rst_n  (rst_n),
        .arb_on (!slave_mode),
        .a_en   (a_en),
        .a_addr (a_addr),
        .b_en   (b_en),
        .b_addr (b_addr),
        .flag_a (arb_a),
        .flag_b (arb_b)
    );

    always_comb begin
        busy_eff_a = slave_mode ? a_busy_i : arb_a;
        busy_eff_b = slave_mode ? b_busy_i : arb_b;
        a_busy_o   = !slave_mode && arb_a;
        b_busy_o   = !slave_mode && arb_b;
        wr_go[0]   = a_en && a_we && !busy_eff_a;
        wr_go[1]   = b_en && b_we && !busy_eff_b;
        rd_go[0]   = a_en && !a_we;
        rd_go[1]   = b_en && !b_we;
        addr_v     = {b_addr, a_addr};
        wdata_v    = {b_wdata, a_wdata};
    end

    dpc_store #(.AW(AW), .DW(DW)) i_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (wr_go),
        .rd_i    (rd_go),
        .addr_i  (addr_v),
        .wdata_i (wdata_v),
        .rdata_o (rdata_v)
    );

    assign a_rdata = rdata_v[0];
    assign b_rdata = rdata_v[1];
endmodule

// File: tb/test_dual_port_collision_ram.sv
module test_dual_port_collision_ram;
    typedef struct packed {
        logic        slv;
        logic        aen, awe;
        logic [11:0] aad;
        logic [15:0] awd;
        logic        abi;
        logic        ben, bwe;
        logic [11:0] bad;
        logic [15:0] bwd;
        logic        bbi;
        logic [1:0]  exp;   // {a_busy_o, b_busy_o}
    } vec_t;

    localparam int NV = 18;
    localparam vec_t TAB [NV] = '{
        '{1'b0, 1'b1,1'b1,12'h010,16'h1111,1'b0, 1'b1,1'b1,12'h020,16'h2222,1'b0, 2'b00},
        '{1'b0, 1'b1,1'b0,12'h010,16'h0000,1'b0, 1'b1,1'b0,12'h020,16'h0000,1'b0, 2'b00},
        '{1'b0, 1'b1,1'b1,12'h030,16'h3333,1'b0, 1'b0,1'b0,12'h000,16'h0000,1'b0, 2'b00},
        '{1'b0, 1'b1,1'b1,12'h030,16'h3333,1'b0, 1'b1,1'b1,12'h030,16'h4444,1'b0, 2'b01},
        '{1'b0, 1'b1,1'b0,12'h030,16'h0000,1'b0, 1'b1,1'b1,12'h030,16'h5555,1'b0, 2'b01},
        '{1'b0, 1'b0,1'b0,12'h000,16'h0000,1'b0, 1'b1,1'b1,12'h030,16'h5555,1'b0, 2'b00},
        '{1'b0, 1'b1,1'b0,12'h030,16'h0000,1'b0, 1'b1,1'b0,12'h030,16'h0000,1'b0, 2'b10},
        '{1'b0, 1'b0,1'b0,12'h000,16'h0000,1'b0, 1'b0,1'b0,12'h000,16'h0000,1'b0, 2'b00},
        '{1'b0, 1'b1,1'b1,12'h010,16'h6666,1'b0, 1'b1,1'b1,12'h010,16'h7777,1'b0, 2'b01},
        '{1'b0, 1'b0,1'b0,12'h000,16'h0000,1'b0, 1'b0,1'b0,12'h000,16'h0000,1'b0, 2'b00},
        '{1'b0, 1'b1,1'b1,12'h020,16'h8888,1'b0, 1'b1,1'b1,12'h020,16'h9999,1'b0, 2'b10},
        '{1'b0, 1'b1,1'b0,12'h010,16'h0000,1'b0, 1'b1,1'b0,12'h020,16'h0000,1'b0, 2'b00},
        '{1'b0, 1'b1,1'b0,12'h010,16'h0000,1'b0, 1'b1,1'b1,12'h010,16'hAAAA,1'b0, 2'b01},
        '{1'b0, 1'b1,1'b1,12'h020,16'hBBBB,1'b0, 1'b1,1'b1,12'h010,16'hAAAA,1'b0, 2'b00},
        '{1'b1, 1'b1,1'b1,12'h020,16'hCCCC,1'b1, 1'b1,1'b1,12'h030,16'hDDDD,1'b0, 2'b00},
        '{1'b1, 1'b1,1'b1,12'h010,16'h1234,1'b0, 1'b1,1'b1,12'h010,16'h5678,1'b0, 2'b00},
        '{1'b1, 1'b1,1'b0,12'h020,16'h0000,1'b1, 1'b1,1'b0,12'h010,16'h0000,1'b0, 2'b00},
        '{1'b0, 1'b1,1'b0,12'h030,16'h0000,1'b0, 1'b0,1'b0,12'h000,16'h0000,1'b0, 2'b00}
    };

    logic        clk = 1'b0;
    logic        rst_n;
    logic        slave_mode;
    logic        a_en, a_we, a_busy_i, a_busy_o;
    logic [11:0] a_addr;
    logic [15:0] a_wdata, a_rdata;
    logic        b_en, b_we, b_busy_i, b_busy_o;
    logic [11:0] b_addr;
    logic [15:0] b_wdata, b_rdata;

    int          n_run = 0;
    int          n_fail = 0;
    bit          done = 1'b0;

    logic [15:0] ref_mem [4096];
    logic        m_aen, m_ben, m_lock, m_loser_b, m_fav_b;
    logic [11:0] m_aad, m_bad;

    always #2 clk = ~clk;

    dual_port_collision_ram i_dual_port_collision_ram (
        .clk(clk), .rst_n(rst_n), .slave_mode(slave_mode),
        .a_en(a_en), .a_we(a_we), .a_addr(a_addr), .a_wdata(a_wdata),
        .a_busy_i(a_busy_i), .a_busy_o(a_busy_o), .a_rdata(a_rdata),
        .b_en(b_en), .b_we(b_we), .b_addr(b_addr), .b_wdata(b_wdata),
        .b_busy_i(b_busy_i), .b_busy_o(b_busy_o), .b_rdata(b_rdata)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic model_reset();
        m_aen = 1'b0; m_ben = 1'b0; m_aad = '0; m_bad = '0;
        m_lock = 1'b0; m_loser_b = 1'b0; m_fav_b = 1'b0;
    endtask

    task automatic idle();
        slave_mode = 1'b0;
        a_en = 1'b0; a_we = 1'b0; a_addr = '0; a_wdata = '0; a_busy_i = 1'b0;
        b_en = 1'b0; b_we = 1'b0; b_addr = '0; b_wdata = '0; b_busy_i = 1'b0;
    endtask

    task automatic apply(input vec_t v);
        slave_mode = v.slv;
        a_en = v.aen; a_we = v.awe; a_addr = v.aad; a_wdata = v.awd; a_busy_i = v.abi;
        b_en = v.ben; b_we = v.bwe; b_addr = v.bad; b_wdata = v.bwd; b_busy_i = v.bbi;
    endtask

    // called just after a falling edge with inputs already applied
    task automatic step(input logic [1:0] tab_exp, input bit from_tab);
        logic        match, held_a, held_b, lb, tie, hit, ea, eb, ba, bb;
        logic        ra, rb;
        logic [15:0] va, vb, old_a, old_b;
        string       tag;
        #1;
        match  = a_en && b_en && (a_addr == b_addr);
        held_a = m_aen && (m_aad == a_addr);
        held_b = m_ben && (m_bad == b_addr);
        lb     = m_loser_b;
        tie    = 1'b0;
        if (match && !(m_lock && held_a && held_b)) begin
            if (held_a && !held_b)      lb = 1'b1;
            else if (held_b && !held_a) lb = 1'b0;
            else begin tie = 1'b1; lb = !m_fav_b; end
        end
        hit = match && !slave_mode;
        ea  = hit && !lb;
        eb  = hit && lb;
        if (from_tab) begin ea = tab_exp[1]; eb = tab_exp[0]; end
        if (slave_mode)      tag = "R6";
        else if (tie)        tag = "R4";
        else if (match)      tag = "R3";
        else                 tag = "R1";
        chk({a_busy_o, b_busy_o} == {ea, eb}, tag, "busy_o {a,b}",
            {30'd0, a_busy_o, b_busy_o}, {30'd0, ea, eb});
        chk(!(a_busy_o && b_busy_o), "R2", "both flagged",
            {30'd0, a_busy_o, b_busy_o}, 32'd0);
        ba = slave_mode ? a_busy_i : ea;
        bb = slave_mode ? b_busy_i : eb;
        ra = a_en && !a_we;  rb = b_en && !b_we;
        va = ref_mem[a_addr]; vb = ref_mem[b_addr];
        old_a = a_rdata;     old_b = b_rdata;
        @(posedge clk);
        if (b_en && b_we && !bb) ref_mem[b_addr] = b_wdata;
        if (a_en && a_we && !ba) ref_mem[a_addr] = a_wdata;
        m_aen = a_en; m_ben = b_en; m_aad = a_addr; m_bad = b_addr;
        m_lock = hit; m_loser_b = lb;
        if (tie && !slave_mode) m_fav_b = lb;
        #1;
        if (ra) chk(a_rdata === va, "R5 R8", "a_rdata", {16'd0, a_rdata}, {16'd0, va});
        else    chk(a_rdata === old_a, "R9", "a_rdata hold", {16'd0, a_rdata}, {16'd0, old_a});
        if (rb) chk(b_rdata === vb, "R5 R8", "b_rdata", {16'd0, b_rdata}, {16'd0, vb});
        else    chk(b_rdata === old_b, "R9", "b_rdata hold", {16'd0, b_rdata}, {16'd0, old_b});
        @(negedge clk);
    endtask

    task automatic read_word(input logic [11:0] ad, input logic [15:0] exp, input string req);
        idle();
        b_en = 1'b1; b_addr = ad;
        @(posedge clk);
        #1;
        chk(b_rdata === exp, req, "readback", {16'd0, b_rdata}, {16'd0, exp});
        @(negedge clk);
        idle();
        m_aen = 1'b0; m_ben = 1'b1; m_bad = ad; m_lock = 1'b0;
    endtask

    task automatic do_reset();
        idle();
        rst_n = 1'b0;
        model_reset();
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk(!a_busy_o && !b_busy_o, "R10", "busy after reset",
            {30'd0, a_busy_o, b_busy_o}, 32'd0);
        chk(a_rdata == 16'd0 && b_rdata == 16'd0, "R10", "rdata after reset",
            {a_rdata, b_rdata}, 32'd0);
        @(negedge clk);
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [11:0] ra_q, rb_q;
        idle();
        rst_n = 1'b0;
        @(negedge clk);
        do_reset();

        // directed vectors: holders win (R3), ties alternate (R4),
        // slave gating (R6), slave same-word writes (R7)
        for (int i = 0; i < NV; i++) begin
            apply(TAB[i]);
            step(TAB[i].exp, 1'b1);
        end
        idle();
        read_word(12'h010, 16'h1234, "R7");
        read_word(12'h020, 16'hBBBB, "R6");
        read_word(12'h030, 16'hDDDD, "R5");

        // reset in mid-run: memory kept, registers cleared (R10)
        do_reset();
        read_word(12'h020, 16'hBBBB, "R10");

        // random master-mode traffic on three shared words
        ra_q = 12'h010;
        rb_q = 12'h020;
        for (int n = 0; n < 600; n++) begin
            if ($urandom_range(0, 1) == 0) ra_q = 12'h010 * (12'd1 + 12'($urandom_range(0, 2)));
            if ($urandom_range(0, 1) == 0) rb_q = 12'h010 * (12'd1 + 12'($urandom_range(0, 2)));
            slave_mode = 1'b0;
            a_en = ($urandom_range(0, 3) != 0); a_we = $urandom_range(0, 1) == 1;
            a_addr = ra_q; a_wdata = 16'($urandom); a_busy_i = 1'b0;
            b_en = ($urandom_range(0, 3) != 0); b_we = $urandom_range(0, 1) == 1;
            b_addr = rb_q; b_wdata = 16'($urandom); b_busy_i = 1'b0;
            step(2'b00, 1'b0);
        end
        idle();
        for (int k = 1; k <= 3; k++) begin
            read_word(12'(k * 16), ref_mem[12'(k * 16)], "R5");
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule